// File: doc/BRIEF.md
# System Control and Interrupt Hub

This block is the control register file of a companion I/O device. Software reaches it over a byte-wide register bus with an address, a write strobe, write data and a combinational read-data return. The block collects up to eight interrupt lines from sibling sub-blocks into a status byte. It masks that byte and presents a single interrupt to the host processor.

The same register file drives a 24-bit general-purpose output port. Each output bit has its own enable bit, and the level seen on the port is the data bit gated by that enable. A per-bit pulse flags every output whose gated level has just changed, so a neighbour can forward only the edges. A set of clock, PLL and buffer-control words is held purely as storage. Registers wider than a byte are reached through consecutive byte addresses, and each write touches exactly one lane.

Top module: `sysctl_irq_hub`

## Requirements
- R1: Offset 0x08 reads the revision value 0x03 and offset 0x09 reads 0x00. Writes to either offset have no effect on what is read back.
- R2: The interrupt status byte is at 0x50, the interrupt mask byte is at 0x52 and the routing byte is at 0x54. Mask and routing read back the last value written.
- R3: When sub-interrupt input n changes level, status bit n takes the new level at the next clock edge.
- R4: `host_irq` is high exactly when the bitwise AND of the status and mask registers is nonzero.
- R5: Output data bytes sit at 0x78..0x7A and enable bytes at 0x7C..0x7E. Byte k covers bits 8k+7..8k of the 24-bit vector, and `gpo_en` presents the enable vector.
- R6: `gpo_level` equals the data vector ANDed with the enable vector.
- R7: Bit i of `gpo_toggle` is high for exactly the one cycle that follows a clock edge at which gated level bit i changed.
- R8: Storage words are at 0x60 (2 lanes), 0x98 (2), 0x9A (2), 0x9C (4), 0xA0, 0xA1, 0xE0 (1 each) and 0xE4 (2). A write to one byte lane leaves every other lane unchanged.
- R9: A bus write to 0x50 replaces the whole status byte. A sub-interrupt change in the same cycle overrides the written value for its own bit.
- R10: Reads from offsets that map to no register return 0x00, and writes to them change no readable state.
- R11: After reset every register reads zero, apart from the revision value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Byte register offset |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| sub_irq | input | 8 | Level interrupt lines from sub-blocks |
| host_irq | output | 1 | Masked aggregate interrupt |
| gpo_level | output | 24 | Gated output levels |
| gpo_en | output | 24 | Output enable vector |
| gpo_toggle | output | 24 | One-cycle change flag per output bit |

## Verification
Software writes to the status byte and sub-interrupt level changes both update the status register, and they can land on the same clock edge. The bench creates this collision on purpose, writing all zeros while a line rises and all ones while a line falls. It then checks that only the edging bit departs from the written byte. Random traffic repeats the overlap many times, and the reference model settles every overlap by the priority stated in R9.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned SUB_N    = 8;
  localparam int unsigned GPO_BYTES = 3;
  localparam int unsigned GPO_W    = GPO_BYTES * DATA_W;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam byte_t REV_VALUE = 8'h03;
  localparam addr_t A_REV_LO  = 8'h08;
  localparam addr_t A_REV_HI  = 8'h09;
  localparam addr_t A_STATUS  = 8'h50;
  localparam addr_t A_MASK    = 8'h52;
  localparam addr_t A_ROUTE   = 8'h54;
  localparam int unsigned A_GPO_DATA = 32'h78;
  localparam int unsigned A_GPO_EN   = 32'h7C;

  localparam int unsigned STORE_N = 8;
  typedef int unsigned store_tbl_t [STORE_N];
  localparam store_tbl_t STORE_BASE  = '{32'h60, 32'h98, 32'h9A, 32'h9C,
                                         32'hA0, 32'hA1, 32'hE0, 32'hE4};
  localparam store_tbl_t STORE_LANES = '{2, 2, 2, 4, 1, 1, 1, 2};
endpackage

// File: rtl/sysctl_lane_reg.sv
module sysctl_lane_reg
  import sysctl_pkg::*;
#(
  parameter int unsigned BASE  = 32'h60,
  parameter int unsigned LANES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  addr_t bus_addr,
  input  logic  bus_we,
  input  byte_t bus_wdata,
  output byte_t rd_data
);
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic             hit;
  logic [IDX_W-1:0] idx;
  byte_t            lane_q [LANES];
  byte_t            lane_d [LANES];
  logic [LANES-1:0] lane_en;

  always_comb begin
    hit = (32'(bus_addr) >= BASE) && (32'(bus_addr) < BASE + LANES);
    idx = IDX_W'(32'(bus_addr) - BASE);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      lane_en[i] = bus_we && hit && (32'(idx) == i);
      lane_d[i]  = lane_en[i] ? bus_wdata : lane_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q[i] <= '0;
      else        lane_q[i] <= lane_d[i];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < LANES; i++) begin
      if (hit && (32'(idx) == i)) rd_data = lane_q[i];
    end
  end
endmodule

// File: rtl/sysctl_irq_agg.sv
module sysctl_irq_agg
  import sysctl_pkg::*;
#(
  parameter int unsigned NSUB = SUB_N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  addr_t           bus_addr,
  input  logic            bus_we,
  input  byte_t           bus_wdata,
  input  logic [NSUB-1:0] sub_irq,
  output logic            host_irq,
  output byte_t           rd_data
);
  byte_t           status_q, status_d;
  byte_t           mask_q,   mask_d;
  byte_t           route_q,  route_d;
  logic [NSUB-1:0] sub_q;
  byte_t           edge_v, lvl_v;

  always_comb begin
    edge_v = '0;
    lvl_v  = '0;
    edge_v[NSUB-1:0] = sub_irq ^ sub_q;
    lvl_v[NSUB-1:0]  = sub_irq;

    status_d = (bus_we && bus_addr == A_STATUS) ? bus_wdata : status_q;
    status_d = (status_d & ~edge_v) | (lvl_v & edge_v);
    mask_d   = (bus_we && bus_addr == A_MASK)  ? bus_wdata : mask_q;
    route_d  = (bus_we && bus_addr == A_ROUTE) ? bus_wdata : route_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      route_q  <= '0;
      sub_q    <= '0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
      route_q  <= route_d;
      sub_q    <= sub_irq;
    end
  end

  always_comb begin
    host_irq = |(status_q & mask_q);
    unique case (bus_addr)
      A_STATUS: rd_data = status_q;
      A_MASK:   rd_data = mask_q;
      A_ROUTE:  rd_data = route_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sysctl_gpo_bank.sv
module sysctl_gpo_bank
  import sysctl_pkg::*;
#(
  parameter int unsigned BYTES     = GPO_BYTES,
  parameter int unsigned DATA_BASE = A_GPO_DATA,
  parameter int unsigned EN_BASE   = A_GPO_EN
) (
  input  logic               clk,
  input  logic               rst_n,
  input  addr_t              bus_addr,
  input  logic               bus_we,
  input  byte_t              bus_wdata,
  output logic [BYTES*8-1:0] level,
  output logic [BYTES*8-1:0] en,
  output logic [BYTES*8-1:0] toggle,
  output byte_t              rd_data
);
  localparam int unsigned W = BYTES * 8;

  byte_t          data_q [BYTES];
  byte_t          data_d [BYTES];
  byte_t          en_q   [BYTES];
  byte_t          en_d   [BYTES];
  logic [W-1:0]   prev_q;
  logic [W-1:0]   data_v;

  for (genvar k = 0; k < BYTES; k++) begin : g_byte
    always_comb begin
      data_d[k] = (bus_we && 32'(bus_addr) == DATA_BASE + k) ? bus_wdata : data_q[k];
      en_d[k]   = (bus_we && 32'(bus_addr) == EN_BASE + k)   ? bus_wdata : en_q[k];
      data_v[8*k +: 8] = data_q[k];
      en[8*k +: 8]     = en_q[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[k] <= '0;
        en_q[k]   <= '0;
      end else begin
        data_q[k] <= data_d[k];
        en_q[k]   <= en_d[k];
      end
    end
  end

  always_comb begin
    level  = data_v & en;
    toggle = level ^ prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < BYTES; k++) begin
      if (32'(bus_addr) == DATA_BASE + k) rd_data = data_q[k];
      if (32'(bus_addr) == EN_BASE + k)   rd_data = en_q[k];
    end
  end
endmodule

// File: rtl/sysctl_irq_hub.sv
module sysctl_irq_hub
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bus_addr,
  input  logic             bus_we,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [SUB_N-1:0] sub_irq,
  output logic             host_irq,
  output logic [GPO_W-1:0] gpo_level,
  output logic [GPO_W-1:0] gpo_en,
  output logic [GPO_W-1:0] gpo_toggle
);
  logic  rst_meta_q, rst_sync_q;
  byte_t irq_rd, gpo_rd;
  byte_t store_rd [STORE_N];
  byte_t rev_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sysctl_irq_agg #(.NSUB(SUB_N)) u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .sub_irq   (sub_irq),
    .host_irq  (host_irq),
    .rd_data   (irq_rd)
  );

  sysctl_gpo_bank #(
    .BYTES     (GPO_BYTES),
    .DATA_BASE (A_GPO_DATA),
    .EN_BASE   (A_GPO_EN)
  ) u_gpo (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .level     (gpo_level),
    .en        (gpo_en),
    .toggle    (gpo_toggle),
    .rd_data   (gpo_rd)
  );

  for (genvar g = 0; g < STORE_N; g++) begin : g_store
    sysctl_lane_reg #(
      .BASE  (STORE_BASE[g]),
      .LANES (STORE_LANES[g])
    ) u_word (
      .clk       (clk),
      .rst_n     (rst_sync_q),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .rd_data   (store_rd[g])
    );
  end

  always_comb begin
    rev_rd = (bus_addr == A_REV_LO) ? REV_VALUE : '0;
    bus_rdata = rev_rd | irq_rd | gpo_rd;
    for (int g = 0; g < STORE_N; g++) bus_rdata = bus_rdata | store_rd[g];
  end
endmodule

// File: rtl/sysctl_irq_hub_chk.sv
module sysctl_irq_hub_chk
  import sysctl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       bus_addr,
  input logic [7:0]       bus_rdata,
  input logic [SUB_N-1:0] sub_irq,
  input logic [SUB_N-1:0] sub_q,
  input logic [7:0]       status_q,
  input logic [7:0]       mask_q,
  input logic             host_irq,
  input logic [GPO_W-1:0] gpo_level,
  input logic [GPO_W-1:0] gpo_en,
  input logic [GPO_W-1:0] gpo_toggle
);
  p_rev_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 8'h08 |-> bus_rdata == 8'h03);

  p_edge_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_irq != sub_q) |=>
      ((status_q[SUB_N-1:0] ^ $past(sub_irq)) & $past(sub_irq ^ sub_q)) == '0);

  p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q == 8'h00 |-> !host_irq);

  p_gated_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gpo_level & ~gpo_en) == '0);

  p_toggle_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> gpo_toggle == (gpo_level ^ $past(gpo_level)));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 8'h55 |-> bus_rdata == 8'h00);
endmodule

bind sysctl_irq_hub sysctl_irq_hub_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .sub_irq    (sub_irq),
  .sub_q      (u_irq.sub_q),
  .status_q   (u_irq.status_q),
  .mask_q     (u_irq.mask_q),
  .host_irq   (host_irq),
  .gpo_level  (gpo_level),
  .gpo_en     (gpo_en),
  .gpo_toggle (gpo_toggle)
);

// File: tb/sysctl_irq_hub_tb_top.sv
module sysctl_irq_hub_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr, bus_wdata, bus_rdata;
  logic        bus_we;
  logic [7:0]  sub_irq;
  logic        host_irq;
  logic [23:0] gpo_level, gpo_en, gpo_toggle;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_irq_hub dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sub_irq(sub_irq),
    .host_irq(host_irq), .gpo_level(gpo_level), .gpo_en(gpo_en),
    .gpo_toggle(gpo_toggle)
  );

  // Behavioural reference model
  int unsigned m_status, m_mask, m_route, m_data, m_en, m_prev, m_subp;
  int unsigned m_store [256];

  function automatic bit is_store(int unsigned a);
    return (a == 'h60) || (a == 'h61) || (a >= 'h98 && a <= 'h9F) ||
           (a == 'hA0) || (a == 'hA1) || (a == 'hE0) || (a == 'hE4) || (a == 'hE5);
  endfunction

  function automatic int unsigned exp_rd(int unsigned a);
    if (a == 'h08) return 3;                          // R1
    if (a == 'h50) return m_status;                   // R2
    if (a == 'h52) return m_mask;
    if (a == 'h54) return m_route;
    if (a >= 'h78 && a <= 'h7A) return (m_data >> (8*(a-'h78))) & 'hFF;  // R5
    if (a >= 'h7C && a <= 'h7E) return (m_en >> (8*(a-'h7C))) & 'hFF;
    if (is_store(a)) return m_store[a];               // R8
    return 0;                                         // R10
  endfunction

  function automatic string req_of(int unsigned a);
    if (a == 'h08 || a == 'h09) return "R1";
    if (a == 'h50) return "R3/R9";
    if (a == 'h52 || a == 'h54) return "R2";
    if (a >= 'h78 && a <= 'h7E) return "R5";
    if (is_store(a)) return "R8";
    return "R10";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_status = 0; m_mask = 0; m_route = 0; m_data = 0; m_en = 0;
      m_prev = 0; m_subp = 0;
      for (int i = 0; i < 256; i++) m_store[i] = 0;
    end else begin
      int unsigned edges, a, w;
      a = bus_addr; w = bus_wdata;
      m_prev = m_data & m_en;
      edges  = sub_irq ^ m_subp;
      if (bus_we && a == 'h50) m_status = w;
      m_status = (m_status & ~edges) | (sub_irq & edges);
      m_subp = sub_irq;
      if (bus_we) begin
        if (a == 'h52) m_mask = w;
        if (a == 'h54) m_route = w;
        if (a >= 'h78 && a <= 'h7A)
          m_data = (m_data & ~('hFF << (8*(a-'h78)))) | (w << (8*(a-'h78)));
        if (a >= 'h7C && a <= 'h7E)
          m_en = (m_en & ~('hFF << (8*(a-'h7C)))) | (w << (8*(a-'h7C)));
        if (is_store(a)) m_store[a] = w;
      end
    end
  end

  task automatic chk(string req, int unsigned act, int unsigned exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(req_of(bus_addr), bus_rdata, exp_rd(bus_addr));
    chk("R4", host_irq, ((m_status & m_mask) != 0));
    chk("R5", gpo_en, m_en);
    chk("R6", gpo_level, m_data & m_en);
    chk("R7", gpo_toggle, (m_data & m_en) ^ m_prev);
  endtask

  task automatic step(input logic [7:0] a, input logic we, input logic [7:0] d,
                      input logic [7:0] s);
    bus_addr = a; bus_we = we; bus_wdata = d; sub_irq = s;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    rst_n = 1'b0; bus_addr = 8'h00; bus_we = 1'b0; bus_wdata = 8'h00; sub_irq = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: reset values
    foreach (STORE_LIST[i]) ;
    step(8'h50, 0, 0, 0); chk("R11", bus_rdata, 8'h00);
    step(8'h9C, 0, 0, 0); chk("R11", bus_rdata, 8'h00);
    step(8'h7C, 0, 0, 0); chk("R11", bus_rdata, 8'h00);
    // R1: revision, read-only
    step(8'h08, 0, 0, 0); chk("R1", bus_rdata, 8'h03);
    step(8'h08, 1, 8'h5A, 0);
    step(8'h09, 1, 8'hA5, 0); chk("R1", bus_rdata, 8'h00);
    step(8'h08, 0, 0, 0); chk("R1", bus_rdata, 8'h03);
    // R2: mask and routing
    step(8'h52, 1, 8'h0F, 0); chk("R2", bus_rdata, 8'h0F);
    step(8'h54, 1, 8'hC3, 0); chk("R2", bus_rdata, 8'hC3);
    // R3/R4: sub edges set and clear status, host irq follows mask
    step(8'h50, 0, 0, 8'h01); chk("R3", bus_rdata, 8'h01); chk("R4", host_irq, 1'b1);
    step(8'h50, 0, 0, 8'h81); chk("R3", bus_rdata, 8'h81);
    step(8'h50, 0, 0, 8'h80); chk("R3", bus_rdata, 8'h80); chk("R4", host_irq, 1'b0);
    step(8'h50, 0, 0, 8'h00);
    // R9: write colliding with edges
    step(8'h50, 1, 8'h00, 8'h04); chk("R9", bus_rdata, 8'h04);
    step(8'h50, 1, 8'hFF, 8'h00); chk("R9", bus_rdata, 8'hFB);
    step(8'h50, 1, 8'h00, 8'h00); chk("R9", bus_rdata, 8'h00);
    // R5/R6/R7: output bytes, gating, toggle pulse
    step(8'h79, 1, 8'hF0, 0); chk("R6", gpo_level, 24'h0);
    step(8'h7D, 1, 8'h3C, 0); chk("R6", gpo_level, 24'h003000);
    chk("R7", gpo_toggle, 24'h003000);
    step(8'h7D, 0, 0, 0);     chk("R7", gpo_toggle, 24'h0);
    step(8'h7E, 1, 8'hFF, 0); chk("R5", gpo_en, 24'hFF3C00);
    // R8: lane isolation
    step(8'h98, 1, 8'h11, 0);
    step(8'h99, 1, 8'h22, 0);
    step(8'h98, 0, 0, 0);     chk("R8", bus_rdata, 8'h11);
    step(8'h9E, 1, 8'h77, 0);
    step(8'h9D, 0, 0, 0);     chk("R8", bus_rdata, 8'h00);
    step(8'h9E, 0, 0, 0);     chk("R8", bus_rdata, 8'h77);
    // R10: unmapped
    step(8'h55, 1, 8'hEE, 0); chk("R10", bus_rdata, 8'h00);
    step(8'hFF, 1, 8'hEE, 0); chk("R10", bus_rdata, 8'h00);

    // Random traffic, compared every cycle
    s = 8'h00;
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      int unsigned r;
      r = $urandom;
      case (r % 6)
        0: a = 8'h50;
        1: a = 8'h52;
        2: a = 8'h78 + 8'($urandom % 7);
        3: a = 8'h98 + 8'($urandom % 8);
        4: a = 8'h60 + 8'($urandom % 2);
        default: a = 8'($urandom);
      endcase
      if ((r >> 8) % 4 == 0) s = s ^ (8'h1 << ((r >> 12) % 8));
      step(a, 1'((r >> 16) % 2), 8'($urandom), s);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  localparam int STORE_LIST [1] = '{0};
endmodule